// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block sits on the device side of a NOR-style flash. It builds the status byte that the part returns on a read while an internal program or erase operation is running. It keeps the operating mode (read-array, programming, erasing, erase-suspended, or programming during a suspend), a per-sector erase selection, an internal pulse counter with a failure limit, and the window timer that delays the start of an erase. A separate command decoder delivers decoded commands. The array control reports completion.

Each clock cycle with an output-enable or chip-enable strobe counts as one status read. The read address selects a sector, and that sector decides whether the second toggle bit moves. Bit 6 shows whether the operation is still active. Bit 2 shows whether the addressed sector is selected for erase. Bit 5 reports a failed operation. Bit 3 shows that erasure has begun. When the addressed location should return array contents, the block raises `array_sel` and drives the status byte to zero.

Top module: `emb_op_status`

## Requirements
- R1: After reset the block is in read-array mode with an empty sector selection, `array_sel`=1 and `stat_byte`=0. It returns to that state whenever an operation ends.
- R2: Bit 6 of `stat_byte` inverts after every read while programming, erasing (including the erase-start window), or programming during suspend. It holds its value while erase-suspended.
- R3: Bit 2 inverts after a read whose sector (the top `SEC_W` bits of `rd_addr`) is selected for erase, while erasing, suspended or programming during suspend. A read of an unselected sector leaves it unchanged.
- R4: A read is any cycle with `rd_oe` or `rd_ce` high. A cycle with both high inverts each toggle bit only once.
- R5: Starting a program or erase from read-array clears bits 6 and 2. Starting a program during suspend clears bit 6 only.
- R6: Bit 5 becomes 1 once an operation has been active for `PULSE_LIM` cycles without completing. An erase counts only after its window. Bit 5 stays 1, and `op_done` is ignored, until a reset command.
- R7: A program command whose `cmd_wdata` has a 1 where `cmd_cell` has a 0 is halted: `op_done` is ignored, so bit 5 rises at the limit.
- R8: Command codes on `cmd_op` are 1 program, 2 erase, 3 suspend, 4 resume and 5 reset. A reset acts only while bit 5 is 1. After a failed program during suspend it returns to the suspended state and keeps the selection. Otherwise it returns to read-array, clears the selection and clears bit 5.
- R9: Bit 3 is 0 for `ERASE_WIN` cycles after the most recent accepted erase command and 1 afterwards. The bit stays 1 while suspended and is 0 while programming from read-array. An erase command inside the window adds its sector and restarts the window. After the window, an erase command is ignored.
- R10: A suspend is accepted only while erasing after the window with bit 5 at 0. A resume returns to erasing and restarts the pulse count. A program is accepted while suspended.
- R11: While suspended, a read of an unselected sector gives `array_sel`=1 and `stat_byte`=0. A read of a selected sector gives the status byte.
- R12: `op_done` ends a program (to read-array, or back to suspend for a program started during suspend). It ends an erase to read-array and clears the selection. During the erase window it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_oe | input | 1 | Read strobe from output enable |
| rd_ce | input | 1 | Read strobe from chip enable |
| rd_addr | input | ADDR_W | Read address; top SEC_W bits give the sector |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code |
| cmd_sec | input | SEC_W | Sector for an erase command |
| cmd_wdata | input | DATA_W | Data a program command writes |
| cmd_cell | input | DATA_W | Present content of the target cell |
| op_done | input | 1 | Internal completion of the running operation |
| stat_byte | output | 8 | Status byte (bits 6, 5, 3, 2 used) |
| array_sel | output | 1 | Select array data instead of status |

## Verification
A legal program is read with single strobes, with both strobes together and with chip enable alone. This separates one inversion per read cycle from one per strobe. An illegal program, and an erase left to run, separate the halt path from the pulse limit, and show that completion is ignored after a failure. A two-sector erase read at selected and unselected addresses, before and after suspend, separates the two toggle bits: bit 2 follows the sector and bit 6 follows activity. Commands given at the wrong time (suspend or completion inside the window, erase after the window, reset without a failure) must leave every status bit on the model's track.

// File: rtl/emb_op_status_pkg.sv
package emb_op_status_pkg;

   typedef enum logic [2:0] {
      MD_READ  = 3'd0,
      MD_PROG  = 3'd1,
      MD_ERASE = 3'd2,
      MD_SUSP  = 3'd3,
      MD_SPROG = 3'd4
   } op_mode_e;

   typedef enum logic [2:0] {
      CM_NONE   = 3'd0,
      CM_PROG   = 3'd1,
      CM_ERASE  = 3'd2,
      CM_SUSP   = 3'd3,
      CM_RESUME = 3'd4,
      CM_RESET  = 3'd5
   } op_cmd_e;

   localparam int STAT_T6   = 6;
   localparam int STAT_FAIL = 5;
   localparam int STAT_WIN  = 3;
   localparam int STAT_T2   = 2;

endpackage

// File: rtl/emb_op_timers.sv
module emb_op_timers #(
   parameter int PULSE_LIM = 40,
   parameter int ERASE_WIN = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pcnt_clr,
   input  logic pcnt_run,
   input  logic win_clr,
   input  logic win_run,
   output logic fail,
   output logic win_done
);
   localparam int PCNT_W = $clog2(PULSE_LIM + 1);
   localparam int TMR_W  = $clog2(ERASE_WIN + 1);

   generate
      if (PULSE_LIM < 2) begin : g_bad_lim
         $error("PULSE_LIM must be at least 2");
      end
      if (ERASE_WIN < 1) begin : g_bad_win
         $error("ERASE_WIN must be at least 1");
      end
   endgenerate

   logic [PCNT_W-1:0] pcnt;
   logic [TMR_W-1:0]  tmr;

   assign win_done = (tmr == TMR_W'(ERASE_WIN));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pcnt <= '0;
         fail <= 1'b0;
      end else if (pcnt_clr) begin
         pcnt <= '0;
         fail <= 1'b0;
      end else if (pcnt_run && !fail) begin
         pcnt <= pcnt + 1'b1;
         if (pcnt == PCNT_W'(PULSE_LIM - 1))
            fail <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         tmr <= '0;
      else if (win_clr)
         tmr <= '0;
      else if (win_run && !win_done)
         tmr <= tmr + 1'b1;
   end

endmodule

// File: rtl/emb_op_toggle.sv
module emb_op_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_evt,
   input  logic run6,
   input  logic hit2,
   input  logic clr6,
   input  logic clr2,
   output logic t6,
   output logic t2
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         t6 <= 1'b0;
      else if (clr6)
         t6 <= 1'b0;
      else if (rd_evt && run6)
         t6 <= ~t6;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         t2 <= 1'b0;
      else if (clr2)
         t2 <= 1'b0;
      else if (rd_evt && hit2)
         t2 <= ~t2;
   end

endmodule

// File: rtl/emb_op_ctrl.sv
module emb_op_ctrl
   import emb_op_status_pkg::*;
#(
   parameter int SEC_W  = 3,
   parameter int DATA_W = 8,
   localparam int SEC_N = 1 << SEC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [SEC_W-1:0]  cmd_sec,
   input  logic [DATA_W-1:0] cmd_wdata,
   input  logic [DATA_W-1:0] cmd_cell,
   input  logic              op_done,
   input  logic              win_done,
   input  logic              fail,
   output op_mode_e          mode,
   output logic [SEC_N-1:0]  mask,
   output logic              clr6,
   output logic              clr2,
   output logic              pcnt_clr,
   output logic              win_clr
);

   op_mode_e nxt;
   logic     mask_set, mask_clr, halt_ld, halt, rst_ok;
   logic     c_prog, c_erase, c_susp, c_resume;

   assign c_prog   = cmd_valid && (cmd_op == CM_PROG);
   assign c_erase  = cmd_valid && (cmd_op == CM_ERASE);
   assign c_susp   = cmd_valid && (cmd_op == CM_SUSP);
   assign c_resume = cmd_valid && (cmd_op == CM_RESUME);
   assign rst_ok   = cmd_valid && (cmd_op == CM_RESET) && fail;

   always_comb begin
      nxt      = mode;
      clr6     = 1'b0;
      clr2     = 1'b0;
      pcnt_clr = 1'b0;
      win_clr  = 1'b0;
      mask_set = 1'b0;
      mask_clr = 1'b0;
      halt_ld  = 1'b0;
      case (mode)
         MD_READ: begin
            if (c_prog) begin
               nxt = MD_PROG;  clr6 = 1'b1; clr2 = 1'b1;
               pcnt_clr = 1'b1; halt_ld = 1'b1;
            end else if (c_erase) begin
               nxt = MD_ERASE; clr6 = 1'b1; clr2 = 1'b1;
               pcnt_clr = 1'b1; win_clr = 1'b1; mask_set = 1'b1;
            end
         end
         MD_PROG: begin
            if (rst_ok) begin
               nxt = MD_READ; pcnt_clr = 1'b1;
            end else if (op_done && !fail && !halt) begin
               nxt = MD_READ;
            end
         end
         MD_ERASE: begin
            if (rst_ok) begin
               nxt = MD_READ; pcnt_clr = 1'b1; mask_clr = 1'b1;
            end else if (c_erase && !win_done) begin
               mask_set = 1'b1; win_clr = 1'b1;
            end else if (c_susp && win_done && !fail) begin
               nxt = MD_SUSP;
            end else if (op_done && win_done && !fail) begin
               nxt = MD_READ; mask_clr = 1'b1;
            end
         end
         MD_SUSP: begin
            if (c_resume) begin
               nxt = MD_ERASE; pcnt_clr = 1'b1;
            end else if (c_prog) begin
               nxt = MD_SPROG; clr6 = 1'b1; pcnt_clr = 1'b1; halt_ld = 1'b1;
            end
         end
         MD_SPROG: begin
            if (rst_ok) begin
               nxt = MD_SUSP; pcnt_clr = 1'b1;
            end else if (op_done && !fail && !halt) begin
               nxt = MD_SUSP;
            end
         end
         default: nxt = MD_READ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         mode <= MD_READ;
      else
         mode <= nxt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         halt <= 1'b0;
      else if (halt_ld)
         halt <= |(cmd_wdata & ~cmd_cell);
   end

   genvar gi;
   generate
      for (gi = 0; gi < SEC_N; gi++) begin : g_sec
         always_ff @(posedge clk) begin
            if (!rst_n)
               mask[gi] <= 1'b0;
            else if (mask_clr)
               mask[gi] <= 1'b0;
            else if (mask_set && (cmd_sec == SEC_W'(gi)))
               mask[gi] <= 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/emb_op_status.sv
module emb_op_status
   import emb_op_status_pkg::*;
#(
   parameter int SEC_W     = 3,
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 8,
   parameter int PULSE_LIM = 40,
   parameter int ERASE_WIN = 6,
   parameter bit CE_COUNTS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_oe,
   input  logic              rd_ce,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [SEC_W-1:0]  cmd_sec,
   input  logic [DATA_W-1:0] cmd_wdata,
   input  logic [DATA_W-1:0] cmd_cell,
   input  logic              op_done,
   output logic [7:0]        stat_byte,
   output logic              array_sel
);
   localparam int SEC_N = 1 << SEC_W;

   generate
      if (ADDR_W <= SEC_W) begin : g_bad_addr
         $error("ADDR_W must exceed SEC_W");
      end
   endgenerate

   op_mode_e           mode;
   logic [SEC_N-1:0]   mask;
   logic [SEC_W-1:0]   rd_sec;
   logic               rd_evt, sel_hit;
   logic               clr6, clr2, pcnt_clr, win_clr;
   logic               fail, win_done, t6, t2;
   logic               run6, hit2, pcnt_run, win_run, erase_seen;

   generate
      if (CE_COUNTS) begin : g_rd_both
         assign rd_evt = rd_oe | rd_ce;
      end else begin : g_rd_oe
         assign rd_evt = rd_oe;
      end
   endgenerate

   assign rd_sec  = rd_addr[ADDR_W-1 -: SEC_W];
   assign sel_hit = mask[rd_sec];

   assign run6       = (mode == MD_PROG) || (mode == MD_SPROG) || (mode == MD_ERASE);
   assign erase_seen = (mode == MD_ERASE) || (mode == MD_SUSP) || (mode == MD_SPROG);
   assign hit2       = erase_seen && sel_hit;
   assign pcnt_run   = (mode == MD_PROG) || (mode == MD_SPROG) ||
                       ((mode == MD_ERASE) && win_done);
   assign win_run    = (mode == MD_ERASE);

   emb_op_ctrl #(.SEC_W(SEC_W), .DATA_W(DATA_W)) ctrl_i (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_sec(cmd_sec),
      .cmd_wdata(cmd_wdata), .cmd_cell(cmd_cell), .op_done(op_done),
      .win_done(win_done), .fail(fail),
      .mode(mode), .mask(mask),
      .clr6(clr6), .clr2(clr2), .pcnt_clr(pcnt_clr), .win_clr(win_clr)
   );

   emb_op_timers #(.PULSE_LIM(PULSE_LIM), .ERASE_WIN(ERASE_WIN)) tmr_i (
      .clk(clk), .rst_n(rst_n),
      .pcnt_clr(pcnt_clr), .pcnt_run(pcnt_run),
      .win_clr(win_clr), .win_run(win_run),
      .fail(fail), .win_done(win_done)
   );

   emb_op_toggle tog_i (
      .clk(clk), .rst_n(rst_n), .rd_evt(rd_evt),
      .run6(run6), .hit2(hit2), .clr6(clr6), .clr2(clr2),
      .t6(t6), .t2(t2)
   );

   always_comb begin
      array_sel = (mode == MD_READ) || ((mode == MD_SUSP) && !sel_hit);
      stat_byte = 8'h00;
      if (!array_sel) begin
         stat_byte[STAT_T6]   = t6;
         stat_byte[STAT_FAIL] = fail;
         stat_byte[STAT_WIN]  = erase_seen && win_done;
         stat_byte[STAT_T2]   = t2;
      end
   end

endmodule

// File: rtl/emb_op_status_chk.sv
module emb_op_status_chk #(
   parameter int SEC_N = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rd_oe,
   input logic             rd_ce,
   input logic             cmd_valid,
   input logic [2:0]       cmd_op,
   input logic             op_done,
   input logic [7:0]       stat_byte,
   input logic [2:0]       mode,
   input logic [SEC_N-1:0] mask,
   input logic             t6,
   input logic             fail,
   input logic             win_done
);
   localparam logic [2:0] K_READ  = 3'd0;
   localparam logic [2:0] K_PROG  = 3'd1;
   localparam logic [2:0] K_ERASE = 3'd2;
   localparam logic [2:0] K_SUSP  = 3'd3;
   localparam logic [2:0] K_RST   = 3'd5;

   p_read_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == K_READ) |-> (mask == '0 && !fail));

   p_t6_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == K_SUSP && $past(mode) == K_SUSP) |-> $stable(t6));

   p_dual_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_oe && rd_ce && mode == K_PROG) |=> (t6 != $past(t6)));

   p_fail_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !(cmd_valid && cmd_op == K_RST)) |=> fail);

   p_win_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == K_ERASE && !win_done) |-> !stat_byte[3]);

   p_susp_after_win_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == K_SUSP) |-> win_done);

   p_erase_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == K_ERASE && win_done && op_done && !fail && !cmd_valid) |=> (mask == '0));

endmodule

bind emb_op_status emb_op_status_chk #(.SEC_N(SEC_N)) chk_i (
   .clk(clk), .rst_n(rst_n), .rd_oe(rd_oe), .rd_ce(rd_ce),
   .cmd_valid(cmd_valid), .cmd_op(cmd_op), .op_done(op_done),
   .stat_byte(stat_byte), .mode(mode), .mask(mask),
   .t6(t6), .fail(fail), .win_done(win_done)
);

// File: tb/emb_op_status_tb_top.sv
module emb_op_status_tb_top;
   localparam int SEC_W = 3;
   localparam int ADDR_W = 12;
   localparam int DATA_W = 8;
   localparam int LIM = 40;
   localparam int WIN = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rd_oe = 1'b0, rd_ce = 1'b0, cmd_valid = 1'b0, op_done = 1'b0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [2:0] cmd_op = '0;
   logic [SEC_W-1:0] cmd_sec = '0;
   logic [DATA_W-1:0] cmd_wdata = '0, cmd_cell = '0;
   logic [7:0] stat_byte;
   logic array_sel;

   int vec_n = 0;
   int bad_n = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   emb_op_status #(.SEC_W(SEC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                   .PULSE_LIM(LIM), .ERASE_WIN(WIN)) dut_i (
      .clk(clk), .rst_n(rst_n), .rd_oe(rd_oe), .rd_ce(rd_ce), .rd_addr(rd_addr),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_sec(cmd_sec),
      .cmd_wdata(cmd_wdata), .cmd_cell(cmd_cell), .op_done(op_done),
      .stat_byte(stat_byte), .array_sel(array_sel)
   );

   // reference model: 0 read, 1 program, 2 erase, 3 suspended, 4 program in suspend
   int m_mode, m_pc, m_win;
   bit m_fail, m_t6, m_t2, m_halt;
   logic [7:0] m_mask;
   int n_mode, n_pc, n_win, rs;
   bit n_fail, n_t6, n_t2, n_halt, wdone, act, rdv, rst_ok, cv;
   logic [7:0] n_mask;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 0; m_pc = 0; m_win = 0; m_fail = 0;
         m_t6 = 0; m_t2 = 0; m_halt = 0; m_mask = '0;
      end else begin
         rdv = rd_oe | rd_ce;
         rs = int'(rd_addr[11:9]);
         wdone = (m_win == WIN);
         cv = cmd_valid;
         n_mode = m_mode; n_pc = m_pc; n_win = m_win; n_fail = m_fail;
         n_t6 = m_t6; n_t2 = m_t2; n_halt = m_halt; n_mask = m_mask;
         if (rdv && (m_mode == 1 || m_mode == 2 || m_mode == 4)) n_t6 = !m_t6;
         if (rdv && m_mode >= 2 && m_mask[rs]) n_t2 = !m_t2;
         act = (m_mode == 1) || (m_mode == 4) || (m_mode == 2 && wdone);
         if (act && !m_fail) begin
            n_pc = m_pc + 1;
            if (n_pc == LIM) n_fail = 1;
         end
         if (m_mode == 2 && !wdone) n_win = m_win + 1;
         rst_ok = cv && cmd_op == 3'd5 && m_fail;
         case (m_mode)
            0: if (cv && cmd_op == 3'd1) begin
                  n_mode = 1; n_t6 = 0; n_t2 = 0; n_pc = 0; n_fail = 0;
                  n_halt = |(cmd_wdata & ~cmd_cell);
               end else if (cv && cmd_op == 3'd2) begin
                  n_mode = 2; n_t6 = 0; n_t2 = 0; n_pc = 0; n_fail = 0; n_win = 0;
                  n_mask = 8'b1 << cmd_sec;
               end
            1: if (rst_ok) begin n_mode = 0; n_pc = 0; n_fail = 0; end
               else if (op_done && !m_fail && !m_halt) n_mode = 0;
            2: if (rst_ok) begin n_mode = 0; n_pc = 0; n_fail = 0; n_mask = '0; end
               else if (cv && cmd_op == 3'd2 && !wdone) begin
                  n_mask = m_mask | (8'b1 << cmd_sec); n_win = 0;
               end else if (cv && cmd_op == 3'd3 && wdone && !m_fail) n_mode = 3;
               else if (op_done && wdone && !m_fail) begin n_mode = 0; n_mask = '0; end
            3: if (cv && cmd_op == 3'd4) begin n_mode = 2; n_pc = 0; n_fail = 0; end
               else if (cv && cmd_op == 3'd1) begin
                  n_mode = 4; n_t6 = 0; n_pc = 0; n_fail = 0;
                  n_halt = |(cmd_wdata & ~cmd_cell);
               end
            default: if (rst_ok) begin n_mode = 3; n_pc = 0; n_fail = 0; end
               else if (op_done && !m_fail && !m_halt) n_mode = 3;
         endcase
         m_mode = n_mode; m_pc = n_pc; m_win = n_win; m_fail = n_fail;
         m_t6 = n_t6; m_t2 = n_t2; m_halt = n_halt; m_mask = n_mask;
      end
   end

   function automatic bit exp_arr();
      return (m_mode == 0) || (m_mode == 3 && !m_mask[rd_addr[11:9]]);
   endfunction

   function automatic logic [7:0] exp_stat();
      logic [7:0] v = 8'h00;
      if (!exp_arr()) begin
         v[6] = m_t6;
         v[5] = m_fail;
         v[3] = (m_mode >= 2) && (m_win == WIN);
         v[2] = m_t2;
      end
      return v;
   endfunction

   task automatic cmp_bit(input logic a, input logic e, input string tag);
      if (a !== e) begin
         bad_n++;
         $display("FAIL %s at vector %0d: actual %b expected %b", tag, vec_n, a, e);
      end
   endtask

   task automatic step(input bit oe, input bit ce, input int sec, input int op,
                       input int csec, input logic [7:0] wd, input logic [7:0] cl,
                       input bit dn);
      logic [7:0] e;
      @(negedge clk);
      rd_oe = oe; rd_ce = ce;
      rd_addr = {3'(sec), 9'h0A5};
      cmd_valid = (op != 0); cmd_op = 3'(op); cmd_sec = 3'(csec);
      cmd_wdata = wd; cmd_cell = cl; op_done = dn;
      #1;
      e = exp_stat();
      vec_n++;
      cmp_bit(stat_byte[6], e[6], "R2,R4,R5 bit6");
      cmp_bit(stat_byte[5], e[5], "R6,R7,R8 bit5");
      cmp_bit(stat_byte[3], e[3], "R9 bit3");
      cmp_bit(stat_byte[2], e[2], "R3,R5 bit2");
      cmp_bit(array_sel, exp_arr(), "R11,R1 array_sel");
      cmp_bit(|{stat_byte[7], stat_byte[4], stat_byte[1:0]}, 1'b0, "R1 unused bits");
   endtask

   task automatic nop(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 8'h00, 8'h00, 0);
   endtask
   task automatic rdo(input int s); step(1, 0, s, 0, 0, 8'h00, 8'h00, 0); endtask
   task automatic cmd(input int op, input int s, input logic [7:0] wd, input logic [7:0] cl);
      step(0, 0, 0, op, s, wd, cl, 0);
   endtask
   task automatic done(); step(0, 0, 0, 0, 0, 8'h00, 8'h00, 1); endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      nop(2);
      // R1: reset state seen at the ports
      vec_n++;
      if (array_sel !== 1'b1 || stat_byte !== 8'h00) begin
         bad_n++;
         $display("FAIL R1 reset: actual %b/%h expected 1/00", array_sel, stat_byte);
      end
      // R2 R4 R5: legal program, oe, both strobes, ce alone
      cmd(1, 0, 8'h0F, 8'hFF);
      rdo(1); step(1, 1, 1, 0, 0, 8'h00, 8'h00, 0); step(0, 1, 2, 0, 0, 8'h00, 8'h00, 0);
      rdo(3); nop(2); done(); rdo(1);
      // R7: illegal 0 to 1 program halts, completion ignored, limit raises bit5
      cmd(1, 0, 8'h81, 8'h80);
      for (int i = 0; i < 20; i++) rdo(i % 8);
      done();
      for (int i = 0; i < 30; i++) rdo(2);
      done();
      // R8: reset clears the failure
      cmd(5, 0, 8'h00, 8'h00); rdo(2); nop(1);
      // R9 R3 R10 R12: two-sector erase
      cmd(2, 2, 8'h00, 8'h00); rdo(2);
      cmd(3, 0, 8'h00, 8'h00);          // R10 suspend inside window ignored
      done();                           // R12 completion inside window ignored
      cmd(2, 5, 8'h00, 8'h00); rdo(5); rdo(3);
      nop(WIN + 2);
      cmd(2, 6, 8'h00, 8'h00);          // R9 erase after window ignored
      rdo(6); rdo(2); rdo(5);
      cmd(3, 0, 8'h00, 8'h00);          // R10 suspend
      rdo(2); rdo(2); rdo(5); rdo(3);   // R11 sector 3 selects array
      step(0, 1, 2, 0, 0, 8'h00, 8'h00, 0);
      cmd(1, 0, 8'h11, 8'h11);          // R10 program during suspend
      rdo(2); rdo(4); rdo(5); done(); rdo(4); rdo(2);
      cmd(1, 0, 8'h02, 8'h00);          // R7 R8 illegal program in suspend
      for (int i = 0; i < LIM + 4; i++) rdo(5);
      cmd(5, 0, 8'h00, 8'h00);          // R8 back to suspend, selection kept
      rdo(5); rdo(3); rdo(2);
      cmd(4, 0, 8'h00, 8'h00);          // R10 resume
      rdo(2); rdo(1); done(); rdo(2); nop(1);
      // R6: erase runs into the limit
      cmd(2, 0, 8'h00, 8'h00);
      for (int i = 0; i < WIN + LIM + 5; i++) step(i % 2, 0, 0, 0, 0, 8'h00, 8'h00, 0);
      done(); rdo(0);
      cmd(5, 0, 8'h00, 8'h00); rdo(0);
      // R8: reset without a failure is ignored
      cmd(1, 0, 8'h00, 8'hFF); rdo(0); cmd(5, 0, 8'h00, 8'h00); rdo(0); done(); rdo(0);
      nop(2);
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         bad_n++;
         $display("FAIL R1 watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
         $finish;
      end
   end

endmodule